// File: doc/BRIEF.md
# Delta-Sigma Converter Readout Sequencer

This block is the digital control core of a converter that runs a fixed cycle of conversion, wait and serial readout. After power is good and a power-on-reset interval has run, it starts a conversion. The conversion takes a parameterised number of system clock cycles. When the conversion ends, the block captures the result word supplied by the conversion engine on `conv_data_i` into its output register.

A host reads the word through a slave serial port made of chip select, serial clock and serial data out. The most significant bit appears as soon as chip select goes low. Each falling serial clock edge moves the next bit onto the data line, so the host can sample on rising edges. The readout ends after the last bit or when chip select is released. Either way, the next conversion starts on its own, and no configuration is needed.

The serial clock is brought into the system clock domain through a two-stage synchroniser. Its falling edges are detected there. The serial data line is modelled as a data bit plus an output enable.

Top module: `adc_seq_top`

## Requirements
- R1: While `rst_ni` is low, the block is held in its power-on-reset phase with a cleared output register. `sdo_oe_o` is low while `cs_ni` is high.
- R2: While `pwr_good_i` is low, the block stays in its internal reset state and clears its output register. After `pwr_good_i` rises, exactly POR_CYCLES clock cycles of reset pass, and then a conversion of CONV_CYCLES clock cycles begins.
- R3: The value on `conv_data_i` in the last cycle of a conversion is the word the next readout returns, sent MSB first.
- R4: While `cs_ni` is low during the reset interval or during a conversion, `sdo_o` is driven high to signal busy.
- R5: Once a result is ready, driving `cs_ni` low places bit DATA_W-1 of the result on `sdo_o` in the same cycle, before any serial clock edge.
- R6: Each falling edge of `sck_i` with `cs_ni` low moves the next lower bit onto `sdo_o`, no more than three system clock cycles after the edge. `sdo_o` does not change at any other time during a readout. Each serial clock phase must last at least four system clock cycles.
- R7: After the DATA_W-th falling edge, the readout ends and a new conversion starts. If `cs_ni` is still low, `sdo_o` then reads high (busy).
- R8: Raising `cs_ni` during a readout ends it at once and starts a new conversion.
- R9: A ready result is held for as long as `cs_ni` stays high. Serial clock edges while `cs_ni` is high have no effect on it.
- R10: `sdo_oe_o` is high exactly when `cs_ni` is low. `sdo_o` is low whenever `sdo_oe_o` is low.
- R11: A result is returned in at most one readout. After a readout is cut short, the next readout returns the next conversion's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply good; low holds the block in reset |
| cs_ni | input | 1 | Active-low chip select from the host |
| sck_i | input | 1 | Serial clock from the host |
| conv_data_i | input | DATA_W | Result word from the conversion engine |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for serial data out (low = high impedance) |

## Verification
The bench keeps DATA_W at 32 and shrinks POR_CYCLES to 20 and CONV_CYCLES to 40. With those values, a full readout takes about 512 cycles, so many complete cycles fit in one run. These cycles include a power loss in the middle of a conversion, a readout cut short, chip select held low through a conversion, and serial clock activity while the device is deselected. Because the reset and conversion intervals are short, the bench can also check the exact cycle in which busy ends and a result appears on the line.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sck_sync.sv
module adc_seq_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic fall_o
);
  localparam int W = STAGES + 1;
  logic [W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[W-2:0], sck_i};
  end

  // last stage holds previous synchronised value
  assign fall_o = pipe_q[W-1] & ~pipe_q[W-2];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (done_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  logic [DATA_W-1:0] sr_q;
  logic [BW-1:0]     bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      bit_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
      bit_q <= last_o ? '0 : bit_q + 1'b1;
    end
  end

  assign msb_o  = sr_q[DATA_W-1];
  assign last_o = (bit_q == LAST_BIT);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int POR_CYCLES  = 64,
  parameter int CONV_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  seq_state_e state_q, state_d;
  logic por_done, conv_done, sck_fall, sr_msb, sr_last;
  logic shift_en, shift_end, busy;

  adc_seq_sck_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .fall_o(sck_fall)
  );

  adc_seq_timer #(.LIMIT(POR_CYCLES)) u_por_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!pwr_good_i),
    .en_i  (pwr_good_i && state_q == ST_POR),
    .done_o(por_done)
  );

  adc_seq_timer #(.LIMIT(CONV_CYCLES)) u_conv_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!pwr_good_i),
    .en_i  (pwr_good_i && state_q == ST_CONV),
    .done_o(conv_done)
  );

  assign shift_en  = pwr_good_i && state_q == ST_SHIFT && !cs_ni && sck_fall;
  assign shift_end = pwr_good_i && state_q == ST_SHIFT && (cs_ni || (sck_fall && sr_last));

  adc_seq_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!pwr_good_i),
    .load_i (conv_done),
    .data_i (conv_data_i),
    .shift_i(shift_en),
    .msb_o  (sr_msb),
    .last_o (sr_last)
  );

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = ST_POR;
    end else begin
      unique case (state_q)
        ST_POR:   if (por_done)  state_d = ST_CONV;
        ST_CONV:  if (conv_done) state_d = ST_READY;
        ST_READY: if (!cs_ni)    state_d = ST_SHIFT;
        ST_SHIFT: if (shift_end) state_d = ST_CONV;
        default:                 state_d = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POR;
    else         state_q <= state_d;
  end

  assign busy     = (state_q == ST_POR) || (state_q == ST_CONV);
  assign sdo_oe_o = !cs_ni;
  assign sdo_o    = !cs_ni && (busy ? 1'b1 : sr_msb);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int POR_CYCLES = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       cs_ni,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input seq_state_e state_i,
  input logic       conv_done_i,
  input logic       sck_fall_i,
  input logic       sr_msb_i,
  input logic       sr_last_i,
  input logic       data_msb_i
);
  int unsigned por_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    por_len_q <= 0;
    else if (!pwr_good_i || state_i != ST_POR)      por_len_q <= 0;
    else                                            por_len_q <= por_len_q + 1;
  end

  AST_PG_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> state_i == ST_POR); // R2
  AST_POR_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CONV && $past(state_i) == ST_POR) |-> por_len_q == POR_CYCLES); // R2
  AST_LOAD_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && pwr_good_i) |=> sr_msb_i == $past(data_msb_i)); // R3
  AST_BUSY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && (state_i == ST_POR || state_i == ST_CONV)) |-> sdo_o); // R4
  AST_HOLD_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && state_i == ST_SHIFT && !cs_ni && !sck_fall_i) |=> $stable(sr_msb_i)); // R6
  AST_LAST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && state_i == ST_SHIFT && !cs_ni && sck_fall_i && sr_last_i) |=> state_i == ST_CONV); // R7
  AST_EARLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && state_i == ST_SHIFT && cs_ni) |=> state_i == ST_CONV); // R8
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && state_i == ST_READY && cs_ni) |=> state_i == ST_READY); // R9
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!sdo_oe_o && !sdo_o)); // R10
endmodule

bind adc_seq_top adc_seq_chk #(.POR_CYCLES(POR_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .cs_ni      (cs_ni),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .state_i    (state_q),
  .conv_done_i(conv_done),
  .sck_fall_i (sck_fall),
  .sr_msb_i   (sr_msb),
  .sr_last_i  (sr_last),
  .data_msb_i (conv_data_i[DATA_W-1])
);

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;
  localparam int DW    = 32;
  localparam int PORC  = 20;
  localparam int CONVC = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b0;
  logic cs_ni = 1'b1;
  logic sck_i = 1'b0;
  logic [DW-1:0] conv_data_i = '0;
  logic sdo_o, sdo_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  adc_seq_top #(.DATA_W(DW), .POR_CYCLES(PORC), .CONV_CYCLES(CONVC)) u_adc_seq_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .cs_ni(cs_ni),
    .sck_i(sck_i), .conv_data_i(conv_data_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: phase 0 reset, 1 converting, 2 result waiting, 3 reading
  int m_ph, m_cnt, m_bits;
  logic [DW-1:0] m_word;
  logic m_d1, m_d2, m_d3; // sck as seen through the stated two-stage synchroniser

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_bits = 0; m_word = '0;
      m_d1 = 0; m_d2 = 0; m_d3 = 0;
    end else begin
      bit fell;
      fell = m_d3 && !m_d2;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = sck_i;
      if (!pwr_good_i) begin
        m_ph = 0; m_cnt = 0; m_bits = 0; m_word = '0;
      end else begin
        case (m_ph)
          0: begin m_cnt++; if (m_cnt == PORC) begin m_ph = 1; m_cnt = 0; end end
          1: begin m_cnt++;
             if (m_cnt == CONVC) begin m_ph = 2; m_cnt = 0; m_word = conv_data_i; m_bits = 0; end end
          2: if (!cs_ni) m_ph = 3;
          default: begin
            if (cs_ni) m_ph = 1;
            else if (fell) begin
              m_word = m_word << 1;
              m_bits++;
              if (m_bits == DW) m_ph = 1;
            end
          end
        endcase
      end
    end
  end

  // compare every cycle, 2 ns after the edge
  always @(posedge clk_i) begin
    #2;
    if (!done) begin
      logic exp_sdo;
      exp_sdo = cs_ni ? 1'b0 : ((m_ph <= 1) ? 1'b1 : m_word[DW-1]);
      chk("R10", {31'd0, sdo_oe_o}, {31'd0, !cs_ni});
      if (cs_ni)          chk("R10", {31'd0, sdo_o}, 32'd0);
      else if (m_ph <= 1) chk("R4",  {31'd0, sdo_o}, {31'd0, exp_sdo});
      else if (m_ph == 2) chk("R5",  {31'd0, sdo_o}, {31'd0, exp_sdo});
      else                chk("R6",  {31'd0, sdo_o}, {31'd0, exp_sdo});
    end
  end

  task automatic wait_ready();
    wait (m_ph >= 2);
    @(negedge clk_i);
  endtask

  task automatic read_bits(input int n, output logic [DW-1:0] w);
    cs_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    w = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sck_i = 1'b1;
      #1 w = {w[DW-2:0], sdo_o};
      repeat (7) @(negedge clk_i);
      sck_i = 1'b0;
      repeat (8) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    repeat (5) @(negedge clk_i);
    #1;
    chk("R1", {30'd0, sdo_oe_o, sdo_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    // power not yet good: busy level while selected
    cs_ni = 1'b0; #1;
    chk("R4", {31'd0, sdo_o}, 32'd1);
    @(negedge clk_i); cs_ni = 1'b1;
    conv_data_i = 32'hA5C3_0F1E;
    pwr_good_i = 1'b1;
    // busy must last exactly POR+CONV cycles before the result is ready
    repeat (PORC + CONVC - 1) @(negedge clk_i);
    chk("R2", {30'd0, m_ph[1:0]}, 32'd1);
    wait_ready();
    // serial clock activity while deselected must not disturb the result
    for (int i = 0; i < 6; i++) begin
      sck_i = 1'b1; repeat (6) @(negedge clk_i);
      sck_i = 1'b0; repeat (6) @(negedge clk_i);
    end
    cs_ni = 1'b0; #1;
    chk("R5", {31'd0, sdo_o}, 32'd1);
    read_bits(DW, w);
    chk("R9", w, 32'hA5C3_0F1E);
    chk("R7", {31'd0, sdo_o}, 32'd1);
    cs_ni = 1'b1;
    conv_data_i = 32'h8000_0001;
    repeat (5) @(negedge clk_i);
    cs_ni = 1'b0; #1;
    chk("R4", {31'd0, sdo_o}, 32'd1);
    wait_ready();
    read_bits(DW, w);
    chk("R3", w, 32'h8000_0001);
    cs_ni = 1'b1;
    conv_data_i = 32'h1234_5678;
    wait_ready();
    read_bits(12, w);
    chk("R8", w, 32'h0000_0123);
    cs_ni = 1'b1;
    conv_data_i = 32'h0F0F_F0F0;
    @(negedge clk_i);
    chk("R8", {30'd0, m_ph[1:0]}, 32'd1);
    wait_ready();
    read_bits(DW, w);
    chk("R11", w, 32'h0F0F_F0F0);
    cs_ni = 1'b1;
    conv_data_i = 32'hDEAD_BEEF;
    repeat (10) @(negedge clk_i);
    pwr_good_i = 1'b0;
    repeat (5) @(negedge clk_i);
    pwr_good_i = 1'b1;
    repeat (PORC + CONVC - 1) @(negedge clk_i);
    chk("R2", {30'd0, m_ph[1:0]}, 32'd1);
    wait_ready();
    read_bits(DW, w);
    chk("R2", w, 32'hDEAD_BEEF);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule